// File: doc/BRIEF.md
# Priority DMA Channel Arbiter

This block decides which of six DMA channels may drive a single shared memory bus master. Three receive channels and three transmit channels each raise a request, and each carries its own 4-bit priority level. In priority mode, the requester with the largest priority value wins. A rotating pointer settles ties among the requesters that share that value. A single global input switches priority mode off. The arbiter then rotates fairly among all active requesters and ignores their priority levels.

The arbiter is a two-state machine. In `ST_IDLE` it evaluates the requests every cycle. If any request is present, it registers a one-hot grant and takes the `IDLE_TO_BUSY` transition, so the grant becomes visible one clock after the arbitration cycle. In `ST_BUSY` it holds that grant unchanged, whatever the requests and priorities do, until the granted channel raises its done input. It then takes the `BUSY_TO_IDLE` transition, which removes the grant, and arbitrates again in the following cycle. With no requests it stays in `ST_IDLE` through the `IDLE_STAY` transition. While it waits for done it stays in `ST_BUSY` through the `BUSY_HOLD` transition.

Top module: `dma_prio_arbiter`

## Requirements
- R1: An active-low synchronous reset clears the grant and `grant_valid` and returns the rotating pointer to channel 0. After reset, a set of equal-priority requests from every channel is granted to channel 0 first, even if the reset arrived while a grant was held.
- R2: `grant` is one-hot whenever `grant_valid` is 1, and all zero whenever `grant_valid` is 0.
- R3: A grant is only given to a channel whose request was asserted in the arbitration cycle.
- R4: With `prio_off` = 0, the grant goes to a requesting channel with the largest priority value. Priority values of channels that are not requesting have no effect.
- R5: When several requesting channels share the largest value, the first of them in rising index order, starting at the pointer, wins. After every grant the pointer moves to the channel just above the winner, wrapping from 5 to 0.
- R6: With `prio_off` = 1, priorities are ignored. The grant rotates among all requesting channels, using the same pointer and search order as R5.
- R7: A held grant stays stable until the granted channel asserts its done input. Done inputs of other channels, and changes to requests, priorities or `prio_off`, have no effect while it is held.
- R8: Done on the granted channel removes the grant at the next clock edge. Arbitration then takes place in the following cycle, and the new grant appears one clock after that arbitration cycle.
- R9: In any cycle with no requests, no grant is issued.
- R10: Channel index mapping: receive channel k is index k (grant bit k), and transmit channel k is index 3+k (grant bit 3+k). The priority of receive or transmit channel k occupies bits [4k+3:4k] of `rx_prio` or `tx_prio`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_req | input | 3 | Request per receive channel |
| tx_req | input | 3 | Request per transmit channel |
| rx_done | input | 3 | Transfer-finished pulse per receive channel |
| tx_done | input | 3 | Transfer-finished pulse per transmit channel |
| rx_prio | input | 12 | 4-bit priority per receive channel |
| tx_prio | input | 12 | 4-bit priority per transmit channel |
| prio_off | input | 1 | 1 disables priority arbitration (fair rotation only) |
| grant | output | 6 | One-hot grant, receive channels in bits 0..2, transmit channels in bits 3..5 |
| grant_valid | output | 1 | A grant is currently held |

## Verification
The bench targets tie-breaking across consecutive grants, including the wrap of the pointer from the top index back to 0. A design that did not advance or wrap the pointer would keep granting the same tied channel. It checks that a high priority on an idle channel does not capture the maximum; a design that took the maximum over all channels would grant nobody, or the wrong channel. It checks that a done pulse from a channel that does not hold the grant is ignored; a design that reacted to any done would drop a held grant early. It also checks that a reset arriving mid-grant restores the pointer; a design that left the pointer alone would hand the first grant after reset to channel 1 instead of channel 0.

// File: rtl/dma_arb_pkg.sv
package dma_arb_pkg;
    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_BUSY = 1'b1
    } arb_state_e;
endpackage

// File: rtl/dma_arb_cand.sv
// Marks the requesters still in contention: all of them when priority is
// off, otherwise those whose level equals the maximum among requesters.
module dma_arb_cand #(
    parameter int N     = 6,
    parameter int PRI_W = 4
) (
    input  logic [N-1:0]       req,
    input  logic [N*PRI_W-1:0] prio,
    input  logic               prio_off,
    output logic [N-1:0]       cand
);
    logic [PRI_W-1:0] top_lvl;

    always_comb begin
        top_lvl = '0;
        for (int i = 0; i < N; i++) begin
            if (req[i] && (prio[i*PRI_W +: PRI_W] > top_lvl)) begin
                top_lvl = prio[i*PRI_W +: PRI_W];
            end
        end
    end

    for (genvar g = 0; g < N; g++) begin : g_cand
        assign cand[g] = req[g] && (prio_off || (prio[g*PRI_W +: PRI_W] == top_lvl));
    end
endmodule

// File: rtl/dma_arb_rr.sv
// Picks the first set bit of mask, searching upward from ptr with wrap.
module dma_arb_rr #(
    parameter int N     = 6,
    parameter int IDX_W = 3
) (
    input  logic [N-1:0]     mask,
    input  logic [IDX_W-1:0] ptr,
    output logic [N-1:0]     pick,
    output logic [IDX_W-1:0] pick_idx,
    output logic             hit
);
    always_comb begin
        int j;
        pick     = '0;
        pick_idx = '0;
        hit      = 1'b0;
        j        = 0;
        for (int k = 0; k < N; k++) begin
            j = int'(ptr) + k;
            if (j >= N) j = j - N;
            if (!hit && mask[j]) begin
                hit      = 1'b1;
                pick[j]  = 1'b1;
                pick_idx = IDX_W'(j);
            end
        end
    end
endmodule

// File: rtl/dma_prio_arbiter.sv
module dma_prio_arbiter
    import dma_arb_pkg::*;
#(
    parameter int N_RX  = 3,
    parameter int N_TX  = 3,
    parameter int PRI_W = 4
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [N_RX-1:0]         rx_req,
    input  logic [N_TX-1:0]         tx_req,
    input  logic [N_RX-1:0]         rx_done,
    input  logic [N_TX-1:0]         tx_done,
    input  logic [N_RX*PRI_W-1:0]   rx_prio,
    input  logic [N_TX*PRI_W-1:0]   tx_prio,
    input  logic                    prio_off,
    output logic [N_RX+N_TX-1:0]    grant,
    output logic                    grant_valid
);
    localparam int N     = N_RX + N_TX;
    localparam int IDX_W = (N > 1) ? $clog2(N) : 1;

    // R10: receive channels occupy the low indices, transmit channels follow
    logic [N-1:0]       req_all, done_all, cand, pick;
    logic [N*PRI_W-1:0] prio_all;
    logic [IDX_W-1:0]   pick_idx, ptr_q, ptr_nx;
    logic               hit, rel_hit;
    logic [N-1:0]       grant_q, grant_nx;
    arb_state_e         state_q, state_nx;

    assign req_all  = {tx_req, rx_req};
    assign done_all = {tx_done, rx_done};
    assign prio_all = {tx_prio, rx_prio};

    dma_arb_cand #(.N(N), .PRI_W(PRI_W)) i_cand (
        .req      (req_all),
        .prio     (prio_all),
        .prio_off (prio_off),
        .cand     (cand)
    );

    dma_arb_rr #(.N(N), .IDX_W(IDX_W)) i_rr (
        .mask     (cand),
        .ptr      (ptr_q),
        .pick     (pick),
        .pick_idx (pick_idx),
        .hit      (hit)
    );

    assign rel_hit = |(done_all & grant_q);

    // Next state: IDLE_STAY, IDLE_TO_BUSY, BUSY_HOLD, BUSY_TO_IDLE
    always_comb begin
        state_nx = state_q;
        grant_nx = grant_q;
        ptr_nx   = ptr_q;
        unique case (state_q)
            ST_IDLE: begin
                if (hit) begin
                    state_nx = ST_BUSY;
                    grant_nx = pick;
                    ptr_nx   = (pick_idx == IDX_W'(N - 1)) ? '0 : pick_idx + IDX_W'(1);
                end
            end
            ST_BUSY: begin
                if (rel_hit) begin
                    state_nx = ST_IDLE;
                    grant_nx = '0;
                end
            end
            default: begin
                state_nx = ST_IDLE;
                grant_nx = '0;
            end
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            grant_q <= '0;
            ptr_q   <= '0;
        end else begin
            state_q <= state_nx;
            grant_q <= grant_nx;
            ptr_q   <= ptr_nx;
        end
    end

    // Outputs
    always_comb begin
        grant       = grant_q;
        grant_valid = (state_q == ST_BUSY);
    end

    p_grant_shape_r2: assert property (@(posedge clk) disable iff (!rst_n)
        grant_valid |-> ($countones(grant) == 1))
        else $error("grant not one-hot while valid");

    p_grant_clear_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !grant_valid |-> (grant == '0))
        else $error("grant bits set while not valid");

    p_grant_legal_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(grant_valid) |-> ((grant & $past(req_all)) != '0))
        else $error("grant to a channel that was not requesting");

    p_grant_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (grant_valid && ((done_all & grant) == '0)) |=> (grant_valid && $stable(grant)))
        else $error("held grant changed without done");

    p_grant_release_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (grant_valid && ((done_all & grant) != '0)) |=> !grant_valid)
        else $error("grant not released after done");

    p_no_req_no_grant_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!grant_valid && (req_all == '0)) |=> !grant_valid)
        else $error("grant issued with no requests");
endmodule

// File: tb/test_dma_prio_arbiter.sv
`timescale 1ns/1ps
module test_dma_prio_arbiter;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [5:0]  req = '0;
    logic [5:0]  done = '0;
    logic [23:0] prio = '0;
    logic        prio_off = 1'b0;
    logic [5:0]  grant;
    logic        grant_valid;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    dma_prio_arbiter i_dma_prio_arbiter (
        .clk         (clk),
        .rst_n       (rst_n),
        .rx_req      (req[2:0]),
        .tx_req      (req[5:3]),
        .rx_done     (done[2:0]),
        .tx_done     (done[5:3]),
        .rx_prio     (prio[11:0]),
        .tx_prio     (prio[23:12]),
        .prio_off    (prio_off),
        .grant       (grant),
        .grant_valid (grant_valid)
    );

    // {prio_off, req, prio (channel i at [4i+3:4i]), expected grant}
    localparam int NV = 10;
    localparam logic [36:0] VEC [NV] = '{
        {1'b0, 6'b111111, 24'h000000, 6'b000001}, // R1 R5 pointer starts at 0
        {1'b0, 6'b111111, 24'h000000, 6'b000010}, // R5 pointer advanced
        {1'b0, 6'b111111, 24'h393333, 6'b010000}, // R4 R10 tx channel 1 highest
        {1'b0, 6'b000101, 24'h00010F, 6'b000001}, // R4 ch0 level 15 beats ch2
        {1'b0, 6'b100010, 24'h20F010, 6'b100000}, // R4 idle ch3 level ignored
        {1'b1, 6'b001010, 24'h00F000, 6'b000010}, // R6 priority ignored
        {1'b1, 6'b111111, 24'h12345F, 6'b000100}, // R6 rotation continues
        {1'b0, 6'b001001, 24'h007E07, 6'b001000}, // R5 tie, pointer at 3
        {1'b0, 6'b001001, 24'h007E07, 6'b000001}, // R5 tie, pointer wraps
        {1'b1, 6'b000001, 24'h000000, 6'b000001}  // R6 single requester
    };

    task automatic check(input string tag, input logic [5:0] exp_g, input logic exp_v);
        n_checks++;
        if (grant !== exp_g || grant_valid !== exp_v) begin
            n_fail++;
            $display("FAIL %s: grant=%b valid=%b expected grant=%b valid=%b",
                     tag, grant, grant_valid, exp_g, exp_v);
        end
    endtask

    task automatic cyc();
        @(posedge clk);
        @(negedge clk);
    endtask

    initial begin
        #(200000 * 5);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        cyc();
        cyc();
        check("R1 reset state", 6'b000000, 1'b0);
        rst_n = 1'b1;
        cyc();
        check("R9 idle without requests", 6'b000000, 1'b0);

        for (int v = 0; v < NV; v++) begin
            prio_off = VEC[v][36];
            req      = VEC[v][35:30];
            prio     = VEC[v][29:6];
            cyc();
            check($sformatf("R4/R5/R6 vector %0d", v), VEC[v][5:0], 1'b1);
            done = VEC[v][5:0];
            req  = '0;
            cyc();
            done = '0;
            check($sformatf("R8 release vector %0d", v), 6'b000000, 1'b0);
        end
        // pointer now at 1

        // R7: foreign done and input changes leave held grant alone
        prio_off = 1'b0;
        prio     = 24'h000000;
        req      = 6'b000100;
        cyc();
        check("R7 grant ch2", 6'b000100, 1'b1); // pointer now 3
        done = 6'b000001;
        req  = 6'b111111;
        prio = 24'hF00000;
        prio_off = 1'b1;
        cyc();
        check("R7 held against foreign done", 6'b000100, 1'b1);
        prio_off = 1'b0;
        cyc();
        check("R7 held after input change", 6'b000100, 1'b1);
        done = 6'b000100;
        cyc();
        done = '0;
        check("R8 grant dropped after own done", 6'b000000, 1'b0);
        cyc();
        check("R8 new grant one clock after arbitration", 6'b100000, 1'b1); // pointer 0
        done = 6'b100000;
        req  = '0;
        cyc();
        done = '0;
        cyc();
        cyc();
        check("R9 no requests no grant", 6'b000000, 1'b0);

        // R1: reset mid-grant restores pointer
        prio = 24'h000000;
        req  = 6'b111111;
        cyc();
        check("R5 grant ch0 before reset", 6'b000001, 1'b1); // pointer 1
        rst_n = 1'b0;
        cyc();
        check("R1 reset clears held grant", 6'b000000, 1'b0);
        rst_n = 1'b1;
        cyc();
        check("R1 pointer back at channel 0", 6'b000001, 1'b1);
        done = 6'b000001;
        req  = '0;
        cyc();
        done = '0;
        check("R8 final release", 6'b000000, 1'b0);

        finished = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule